// File: doc/BRIEF.md
# CRC-Protected SPI Register Target

This block is an SPI target that gives a host access to a small bank of 16-bit registers. Every transaction is one 32-bit frame under a single chip-select assertion, sent most significant bit first. The request carries a 7-bit register address, a direction bit, 16 data bits and an 8-bit CRC over the first 24 bits. The target checks the CRC and the frame length, then performs the access. On the next transaction it returns a status byte, the read data and a fresh CRC. Three sticky error flags record a bad CRC, a wrong clock count and an invalid request. The host clears them by writing ones to a flag register.

The serial pins are sampled in the system clock domain, and the controller is a three-state machine. ST_IDLE waits for chip select to fall, which moves it to ST_SHIFT. ST_SHIFT collects bits on falling SCK edges. When chip select rises it moves to ST_DECODE if exactly 32 falling edges were seen. Otherwise it raises the clock-count error and returns to ST_IDLE. ST_DECODE lasts one cycle. It checks the CRC, performs the access and latches the response data, then returns to ST_IDLE, or goes to ST_SHIFT if a new frame has already started. The serial inputs must already be synchronous to `clk`, and SCK must be well below half the clock rate.

Top module: `spi_crc_target`

## Requirements
- R1: Bus mode 1. MOSI is captured on falling SCK edges. While chip select (active low) is asserted, MISO changes only after rising SCK edges. While chip select is deasserted and after reset, MISO is 0.
- R2: Request layout: bits 31:25 hold the address, bit 24 is the direction (1 = write, 0 = read), bits 23:8 hold the write data and bits 7:0 hold the CRC.
- R3: The CRC is CRC-8 with polynomial 0x1D and seed 0xFF. It is processed MSB first over frame bits 31:8, with no final inversion. The response carries such a CRC over its own bits 31:8.
- R4: The response is one frame late. Bits 31:24 are the status byte {5'b0, invalid-request, clock-count, crc} (bits 2, 1, 0), taken when chip select falls. Bits 23:8 hold the read data of the previous frame, or 0 if that frame was a write or failed. The first frame after reset returns status 0 and data 0.
- R5: Register map:
  - Address 0x00 is a read-only identifier, 0x5A3C.
  - Address 0x01 is the flag register. A read returns the three flags in bits 2:0. A write clears every flag whose data bit is 1.
  - Addresses 0x02 to 0x05 are read/write scratch registers that reset to 0.
- R6: A CRC mismatch sets the crc flag. The access is not performed.
- R7: If chip select rises after a falling-SCK count other than 32, the clock-count flag is set and the frame is ignored.
- R8: An invalid request sets the invalid-request flag and changes no register. A request is invalid if it uses an unimplemented address, writes to address 0x00, or is a read with nonzero data bits.
- R9: Each flag stays set until it is cleared through R5. Frames that do not clear a flag leave it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
A wrong state appears at the ports no later than the next frame. The next frame's status byte exposes a wrong flag, and its data field exposes a wrong register value or wrong access decode. Any mismatch between the response bits and the response CRC shows an error in CRC generation. A shift or edge-count fault corrupts bits of the frame being shifted. The reference model predicts every response bit and also checks that MISO is low between frames.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
    localparam int FRAME_W = 32;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 16;
    localparam int CRC_W   = 8;
    localparam int FLAG_W  = 3;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h1D;
    localparam logic [CRC_W-1:0] CRC_SEED = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_DECODE = 2'd2
    } tgt_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] data;
        logic [CRC_W-1:0]  crc;
    } frame_t;

    // CRC-8, MSB first, no final inversion
    function automatic logic [CRC_W-1:0] crc8_calc(input logic [FRAME_W-CRC_W-1:0] payload);
        logic [CRC_W-1:0] c;
        c = CRC_SEED;
        for (int i = FRAME_W - CRC_W - 1; i >= 0; i--) begin
            if (c[CRC_W-1] ^ payload[i])
                c = {c[CRC_W-2:0], 1'b0} ^ CRC_POLY;
            else
                c = {c[CRC_W-2:0], 1'b0};
        end
        return c;
    endfunction
endpackage

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
    import spi_tgt_pkg::*;
#(
    parameter int CNT_W = $clog2(FRAME_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               mosi,
    input  logic [FRAME_W-1:0] tx_frame,
    output logic               miso,
    output logic               cs_fall,
    output logic               cs_rise,
    output logic [CNT_W-1:0]   edge_cnt,
    output logic [FRAME_W-1:0] rx_frame
);
    logic [1:0]         sck_s, cs_s;
    logic               mosi_s, sel, sck_rise, sck_fall, miso_q;
    logic [FRAME_W-1:0] tx_sh, rx_sh;
    logic [CNT_W-1:0]   cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s  <= 2'b00;
            cs_s   <= 2'b11;
            mosi_s <= 1'b0;
        end else begin
            sck_s  <= {sck_s[0], sck};
            cs_s   <= {cs_s[0], cs_n};
            mosi_s <= mosi;
        end
    end

    assign sck_rise = sck_s[0] & ~sck_s[1];
    assign sck_fall = ~sck_s[0] & sck_s[1];
    assign cs_fall  = ~cs_s[0] & cs_s[1];
    assign cs_rise  = cs_s[0] & ~cs_s[1];
    assign sel      = ~cs_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            rx_sh  <= '0;
            cnt    <= '0;
            miso_q <= 1'b0;
        end else if (cs_fall) begin
            tx_sh  <= tx_frame;
            rx_sh  <= '0;
            cnt    <= '0;
            miso_q <= 1'b0;
        end else if (sel) begin
            if (sck_rise) begin
                miso_q <= tx_sh[FRAME_W-1];
                tx_sh  <= {tx_sh[FRAME_W-2:0], 1'b0};
            end
            if (sck_fall) begin
                rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
                if (cnt != '1) cnt <= cnt + 1'b1;
            end
        end else begin
            miso_q <= 1'b0;
        end
    end

    assign miso     = miso_q;
    assign edge_cnt = cnt;
    assign rx_frame = rx_sh;

    // R1
    miso_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !sck_rise && !cs_fall) |=> $stable(miso_q));
    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_fall) |=> $stable(cnt));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_tgt_pkg::*;
#(
    parameter logic [DATA_W-1:0] DEV_ID       = 16'h5A3C,
    parameter int                NUM_SCRATCH  = 4,
    parameter int                SCRATCH_BASE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              set_crc_err,
    input  logic              set_clk_err,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_bad,
    output logic [FLAG_W-1:0] err_flags
);
    localparam int SIDX_W = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1;
    localparam logic [ADDR_W-1:0] ID_ADDR   = 7'd0;
    localparam logic [ADDR_W-1:0] FLAG_ADDR = 7'd1;
    localparam logic [ADDR_W-1:0] SCR_LO    = ADDR_W'(SCRATCH_BASE);
    localparam logic [ADDR_W-1:0] SCR_HI    = ADDR_W'(SCRATCH_BASE + NUM_SCRATCH);

    logic [DATA_W-1:0] scr [NUM_SCRATCH];
    logic [FLAG_W-1:0] flags_q, flags_d;
    logic              is_id, is_flag, is_scr, do_write;
    logic [SIDX_W-1:0] sidx;

    always_comb begin
        is_id    = (acc_addr == ID_ADDR);
        is_flag  = (acc_addr == FLAG_ADDR);
        is_scr   = (acc_addr >= SCR_LO) && (acc_addr < SCR_HI);
        sidx     = SIDX_W'(acc_addr - SCR_LO);
        acc_bad  = !(is_id || is_flag || is_scr) || (acc_wr && is_id) ||
                   (!acc_wr && (acc_wdata != '0));
        do_write = acc_en && acc_wr && !acc_bad;
        if (is_id)        acc_rdata = DEV_ID;
        else if (is_flag) acc_rdata = DATA_W'(flags_q);
        else if (is_scr)  acc_rdata = scr[sidx];
        else              acc_rdata = '0;
    end

    for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                scr[g] <= '0;
            else if (do_write && is_scr && (sidx == SIDX_W'(g)))
                scr[g] <= acc_wdata;
        end
        // R8
        bad_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en && acc_wr && acc_bad) |=> $stable(scr[g]));
    end

    always_comb begin
        flags_d = flags_q;
        if (do_write && is_flag) flags_d = flags_d & ~acc_wdata[FLAG_W-1:0];
        if (set_crc_err)         flags_d[0] = 1'b1;
        if (set_clk_err)         flags_d[1] = 1'b1;
        if (acc_en && acc_bad)   flags_d[2] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign err_flags = flags_q;

    // R9
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && acc_wr && is_flag) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/spi_crc_target.sv
module spi_crc_target
    import spi_tgt_pkg::*;
#(
    parameter logic [DATA_W-1:0] DEV_ID       = 16'h5A3C,
    parameter int                NUM_SCRATCH  = 4,
    parameter int                SCRATCH_BASE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    localparam int CNT_W = $clog2(FRAME_W) + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

    tgt_state_e         state_q, state_d;
    logic               cs_fall, cs_rise, crc_ok;
    logic               acc_en, set_crc, set_clk, acc_bad;
    logic [CNT_W-1:0]   edge_cnt;
    logic [FRAME_W-1:0] rx_bits, tx_frame;
    frame_t             rx;
    logic [DATA_W-1:0]  rdata, resp_q;
    logic [FLAG_W-1:0]  err_flags;
    logic [7:0]         status;

    spi_shift_unit #(.CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .tx_frame(tx_frame), .miso(miso), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .edge_cnt(edge_cnt), .rx_frame(rx_bits)
    );

    assign rx     = frame_t'(rx_bits);
    assign crc_ok = (crc8_calc(rx_bits[FRAME_W-1:CRC_W]) == rx.crc);

    spi_reg_bank #(
        .DEV_ID(DEV_ID), .NUM_SCRATCH(NUM_SCRATCH), .SCRATCH_BASE(SCRATCH_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(rx.wr),
        .acc_addr(rx.addr), .acc_wdata(rx.data), .set_crc_err(set_crc),
        .set_clk_err(set_clk), .acc_rdata(rdata), .acc_bad(acc_bad),
        .err_flags(err_flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_d = (edge_cnt == FULL_CNT) ? ST_DECODE : ST_IDLE;
            ST_DECODE: state_d = cs_fall ? ST_SHIFT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        acc_en  = (state_q == ST_DECODE) && crc_ok;
        set_crc = (state_q == ST_DECODE) && !crc_ok;
        set_clk = (state_q == ST_SHIFT) && cs_rise && (edge_cnt != FULL_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            resp_q <= '0;
        else if (state_q == ST_DECODE)
            resp_q <= (crc_ok && !acc_bad && !rx.wr) ? rdata : '0;
        else if (set_clk)
            resp_q <= '0;
    end

    assign status   = {{(8-FLAG_W){1'b0}}, err_flags};
    assign tx_frame = {status, resp_q, crc8_calc({status, resp_q})};

    // R6
    crc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && !crc_ok) |=> err_flags[0]);
    // R7
    clk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cs_rise && edge_cnt != FULL_CNT) |=> (err_flags[1] && state_q == ST_IDLE));
    // R4
    resp_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && !crc_ok) |=> (resp_q == '0));
endmodule

// File: tb/spi_crc_target_bench.sv
module spi_crc_target_bench;
    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    int   checks = 0, fails = 0;

    // model state
    logic [15:0] m_scr [4];
    logic [2:0]  m_flags = 3'b000;
    logic [15:0] m_resp  = 16'h0000;

    always #2 clk = ~clk;

    spi_crc_target u_spi_crc_target (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    function automatic logic [7:0] ref_crc(input logic [23:0] d);
        logic [7:0] r = 8'hFF;
        for (int k = 0; k < 24; k++) begin
            logic fb;
            fb = r[7] ^ d[23-k];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h1D;
        end
        return r;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic xfer(input int nedge, input logic [6:0] addr, input logic wr,
                        input logic [15:0] data, input logic corrupt, input string tag);
        logic [31:0] req, exp, got;
        logic [23:0] hdr;
        logic        bad;
        int          n;
        hdr = {addr, wr, data};
        req = {hdr, ref_crc(hdr)};
        if (corrupt) req[0] = ~req[0];
        exp = {5'b0, m_flags, m_resp, ref_crc({5'b0, m_flags, m_resp})};
        got = '0;
        cs_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < nedge; i++) begin
            sck  = 1'b1;
            mosi = (i < 32) ? req[31-i] : 1'b0;
            wait_clk(8);
            if (i < 32) got = {got[30:0], miso};
            sck = 1'b0;
            wait_clk(8);
        end
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(12);
        n = (nedge > 32) ? 32 : nedge;
        if (n > 0) check(tag, got, exp >> (32 - n));
        check("R1 miso low when deselected", {31'b0, miso}, 32'h0);
        // reference model update
        if (nedge != 32) begin
            m_flags[1] = 1'b1; m_resp = '0;
        end else if (corrupt) begin
            m_flags[0] = 1'b1; m_resp = '0;
        end else begin
            bad = !(addr <= 7'd5) || (wr && addr == 7'd0) || (!wr && data != 16'h0);
            if (bad) begin
                m_flags[2] = 1'b1; m_resp = '0;
            end else if (wr) begin
                if (addr == 7'd1) m_flags = m_flags & ~data[2:0];
                else              m_scr[addr-2] = data;
                m_resp = '0;
            end else begin
                m_resp = (addr == 7'd0) ? 16'h5A3C :
                         (addr == 7'd1) ? {13'b0, m_flags} : m_scr[addr-2];
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_scr[i] = '0;
        wait_clk(5);
        check("R1 miso zero in reset", {31'b0, miso}, 32'h0);
        rst_n = 1'b1;
        wait_clk(5);
        xfer(32, 7'h00, 1'b0, 16'h0, 1'b0, "R4 first frame status and data zero");
        xfer(32, 7'h00, 1'b0, 16'h0, 1'b0, "R5 identifier read R3 crc");
        xfer(32, 7'h02, 1'b1, 16'h1234, 1'b0, "R2 write scratch");
        xfer(32, 7'h05, 1'b1, 16'hBEEF, 1'b0, "R5 write top scratch");
        xfer(32, 7'h02, 1'b0, 16'h0, 1'b0, "R4 one-frame-late data");
        xfer(32, 7'h05, 1'b0, 16'h0, 1'b0, "R5 scratch readback");
        xfer(32, 7'h03, 1'b1, 16'hCAFE, 1'b1, "R5 read previous");
        xfer(32, 7'h03, 1'b0, 16'h0, 1'b0, "R6 crc error status");
        xfer(32, 7'h01, 1'b0, 16'h0, 1'b0, "R6 write discarded");
        xfer(32, 7'h01, 1'b1, 16'h0001, 1'b0, "R5 flag register read");
        xfer(20, 7'h04, 1'b1, 16'h5555, 1'b0, "R4 status after clear");
        xfer(32, 7'h04, 1'b0, 16'h0, 1'b0, "R7 short frame flag");
        xfer(40, 7'h04, 1'b1, 16'h7777, 1'b0, "R7 short frame ignored");
        xfer(32, 7'h04, 1'b0, 16'h0, 1'b0, "R7 long frame partial");
        xfer(0, 7'h00, 1'b0, 16'h0, 1'b0, "R7 empty select");
        xfer(32, 7'h00, 1'b1, 16'h1111, 1'b0, "R7 long frame ignored");
        xfer(32, 7'h10, 1'b0, 16'h0, 1'b0, "R8 write to identifier");
        xfer(32, 7'h02, 1'b0, 16'h00FF, 1'b0, "R8 unimplemented address");
        xfer(32, 7'h02, 1'b0, 16'h0, 1'b0, "R8 read with data");
        xfer(32, 7'h00, 1'b0, 16'h0, 1'b0, "R9 flags stay set");
        xfer(32, 7'h01, 1'b1, 16'h0002, 1'b0, "R9 flags still set");
        xfer(32, 7'h01, 1'b0, 16'h0, 1'b0, "R9 partial clear");
        xfer(32, 7'h01, 1'b1, 16'h0007, 1'b0, "R9 remaining flags");
        xfer(32, 7'h00, 1'b0, 16'h0, 1'b0, "R9 all cleared");
        xfer(32, 7'h00, 1'b0, 16'h0, 1'b0, "R3 clean status");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule